// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt request lines into one processor interrupt. Each request line is fixed at build time as either level sensitive or rising-edge sensitive. Captured requests sit in a status word. An enable word masks them into a pending word. A lowest-index encoder turns the pending word into a vector number that the handler can read. One 32-bit register bus with word addressing reaches all eight control words. All accesses are full words.

Software clears serviced requests through an acknowledge word. It changes the enable word in a single write through separate set-enable and clear-enable words, so no read-modify-write is needed. A two-bit master-control word switches request capture and the processor output independently. While capture is off, software may write the status word directly to raise test or soft interrupts.

Top module: `irq_hub`

## Requirements
- R1: After a synchronous active-low reset, the status, enable and master-control words read 0. The vector word reads 0xFFFFFFFF and `irq_out` is low.
- R2: Address bits [4:2] pick the word and bits [1:0] are ignored. The word index and its meaning: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master-control.
- R3: The pending word reads status AND enable, in the cycle after either of them changes.
- R4: The vector word reads the index of the lowest set pending bit. It reads 0xFFFFFFFF when no pending bit is set.
- R5: A write to the acknowledge word clears each status bit written as 1. A level input that is still high while capture is on sets its bit again in the same cycle.
- R6: A write to set-enable ORs the data into the enable word. A write to clear-enable clears each enable bit written as 1. A write to word 2 replaces the enable word.
- R7: Master-control bit 1 is the capture switch. While it is 0, no input changes the status word.
- R8: A level-mode input (EDGE_MASK bit 0) sets its status bit in every cycle in which it is high and capture is on.
- R9: An edge-mode input (EDGE_MASK bit 1) sets its status bit only when it is high in a cycle after a cycle in which it was low. The previous-cycle sample is tracked even while capture is off, so an input held high does not set its bit again after an acknowledge.
- R10: A write to the status word is ignored while capture is on. While capture is off, the write stores the data.
- R11: `irq_out` is high exactly when master-control bit 0 is 1 and any pending bit is 1. Clearing bit 1 alone does not lower it.
- R12: Writes to the pending and vector words have no effect. The master-control word keeps data bits [1:0]. With READBACK_CMD=1, the acknowledge, set-enable and clear-enable words read back the last data written to them; with READBACK_CMD=0 they read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and capture clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 5 | Byte address; bits [4:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| irq_in | input | N_SRC | Request lines, synchronous to clk |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
The bench builds the block with N_SRC=8, EDGE_MASK=0xF0 and READBACK_CMD=1. Four level-mode and four edge-mode lines then sit side by side, and the command words can be read back. With eight lines, every one of the 256 status patterns can be swept through the vector encoder, and every one of the 256 enable patterns through the pending mask. Directed cases follow. They cover level inputs re-capturing through an acknowledge, edges held high across an acknowledge, turning capture on while inputs are already high, and lowering the capture switch under a live interrupt. A long mixed pseudo-random run of writes and input changes is checked word by word against an arithmetic model.

// File: rtl/irq_hub_pkg.sv
// Shared constants and word selector for the interrupt hub.
package irq_hub_pkg;

    localparam int WORD_W     = 32;
    localparam int BUS_ADDR_W = 5;

    // Word selector; the numbering is the software-visible address layout.
    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_SETEN  = 3'd4,
        SEL_CLREN  = 3'd5,
        SEL_VEC    = 3'd6,
        SEL_MASTER = 3'd7
    } word_sel_e;

endpackage

// File: rtl/irq_capture.sv
// Input capture: turns request lines into per-cycle set pulses for the status word.
// Each line is level or rising-edge sensitive, chosen per bit by EDGE_MASK.
// Assumes irq_in is already synchronous to clk.
module irq_capture #(
    parameter int                N_SRC     = 32,
    parameter logic [N_SRC-1:0]  EDGE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hie,
    input  logic [N_SRC-1:0] irq_in,
    output logic [N_SRC-1:0] cap_bits
);

    logic [N_SRC-1:0] irq_q;

    // Previous-cycle sample of every line, tracked whatever the capture switch says.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_in;
    end

    // Per-line set condition, picked by the line's mode.
    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_line
        if (EDGE_MASK[gi]) begin : g_edge
            assign cap_bits[gi] = hie & irq_in[gi] & ~irq_q[gi];
        end else begin : g_level
            assign cap_bits[gi] = hie & irq_in[gi];
        end
    end

endmodule

// File: rtl/irq_lowest_enc.sv
// Lowest-index encoder: reports the smallest set bit of the pending word.
// It drives all ones on the output when nothing is pending. Purely combinational.
module irq_lowest_enc #(
    parameter int N_SRC = 32,
    parameter int OUT_W = 32
) (
    input  logic [N_SRC-1:0] pend,
    output logic [OUT_W-1:0] vec,
    output logic             any
);

    // Scan from the top down so that the lowest set index wins.
    always_comb begin
        vec = '1;
        any = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                vec = OUT_W'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_regfile.sv
// Register storage: status, enable, master-control and the optional command-word copies.
// It applies the bus write first and the capture pulses after it, within one cycle.
// Assumes at most one write per cycle.
module irq_regfile
    import irq_hub_pkg::*;
#(
    parameter int   N_SRC        = 32,
    parameter bit   READBACK_CMD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  word_sel_e         sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic [N_SRC-1:0]  cap_bits,
    output logic [N_SRC-1:0]  status,
    output logic [N_SRC-1:0]  enable,
    output logic [1:0]        master,
    output logic [WORD_W-1:0] ack_rb,
    output logic [WORD_W-1:0] set_rb,
    output logic [WORD_W-1:0] clr_rb
);

    logic [N_SRC-1:0] status_nx;
    logic [N_SRC-1:0] enable_nx;
    logic [N_SRC-1:0] wd_src;

    assign wd_src = wdata[N_SRC-1:0];

    // Next status: direct store (capture off only), acknowledge, then capture.
    always_comb begin
        status_nx = status;
        if (wr_en && sel == SEL_STATUS && !master[1]) status_nx = wd_src;
        if (wr_en && sel == SEL_ACK)                  status_nx = status_nx & ~wd_src;
        status_nx = status_nx | cap_bits;
    end

    // Next enable: plain write, atomic set or atomic clear.
    always_comb begin
        enable_nx = enable;
        if (wr_en) begin
            case (sel)
                SEL_ENABLE: enable_nx = wd_src;
                SEL_SETEN:  enable_nx = enable | wd_src;
                SEL_CLREN:  enable_nx = enable & ~wd_src;
                default:    enable_nx = enable;
            endcase
        end
    end

    // Status, enable and master-control storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
            master <= '0;
        end else begin
            status <= status_nx;
            enable <= enable_nx;
            if (wr_en && sel == SEL_MASTER) master <= wdata[1:0];
        end
    end

    // Command-word copies exist only when read-back is built in.
    if (READBACK_CMD) begin : g_rb
        // Keep the last data written to each command word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ack_rb <= '0;
                set_rb <= '0;
                clr_rb <= '0;
            end else if (wr_en) begin
                if (sel == SEL_ACK)   ack_rb <= wdata;
                if (sel == SEL_SETEN) set_rb <= wdata;
                if (sel == SEL_CLREN) clr_rb <= wdata;
            end
        end
    end else begin : g_norb
        assign ack_rb = '0;
        assign set_rb = '0;
        assign clr_rb = '0;
    end

    // Acknowledge with capture off leaves no written bit set.
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && sel == SEL_ACK && !master[1]) |-> ((status & $past(wd_src)) == '0));

    // Atomic set leaves every written bit enabled.
    assert_set_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && sel == SEL_SETEN) |-> ((enable & $past(wd_src)) == $past(wd_src)));

    // Atomic clear leaves every written bit disabled.
    assert_clr_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && sel == SEL_CLREN) |-> ((enable & $past(wd_src)) == '0));

    // Capture off and no status write: no new status bit appears.
    assert_no_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!master[1] && !(wr_en && sel == SEL_STATUS)) |-> ((status & ~$past(status)) == '0));

    // Status write while capturing loses no bit.
    assert_status_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && sel == SEL_STATUS && master[1]) |-> ((status & $past(status)) == $past(status)));

endmodule

// File: rtl/irq_hub.sv
// Interrupt hub top: bus decode, read mux and output gating around the
// capture, storage and encoder pieces. Reads are combinational.
// Writes take effect at the next clock edge. Assumes 1 <= N_SRC <= 32.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int               N_SRC        = 32,
    parameter logic [N_SRC-1:0] EDGE_MASK    = '0,
    parameter bit               READBACK_CMD = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    input  logic [N_SRC-1:0]      irq_in,
    output logic                  irq_out
);

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    word_sel_e          sel;
    logic [N_SRC-1:0]   cap_bits;
    logic [N_SRC-1:0]   status;
    logic [N_SRC-1:0]   enable;
    logic [N_SRC-1:0]   pend;
    logic [1:0]         master;
    logic [WORD_W-1:0]  ack_rb;
    logic [WORD_W-1:0]  set_rb;
    logic [WORD_W-1:0]  clr_rb;
    logic [WORD_W-1:0]  vec;
    logic               any_pend;
    logic               unused_addr_bits;

    assign sel              = word_sel_e'(bus_addr[4:2]);
    assign unused_addr_bits = ^bus_addr[1:0];

    irq_capture #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .hie      (master[1]),
        .irq_in   (irq_in),
        .cap_bits (cap_bits)
    );

    irq_regfile #(.N_SRC(N_SRC), .READBACK_CMD(READBACK_CMD)) i_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .sel      (sel),
        .wdata    (bus_wdata),
        .cap_bits (cap_bits),
        .status   (status),
        .enable   (enable),
        .master   (master),
        .ack_rb   (ack_rb),
        .set_rb   (set_rb),
        .clr_rb   (clr_rb)
    );

    assign pend = status & enable;

    irq_lowest_enc #(.N_SRC(N_SRC), .OUT_W(WORD_W)) i_enc (
        .pend (pend),
        .vec  (vec),
        .any  (any_pend)
    );

    // Processor output: the output switch gates any pending request.
    assign irq_out = master[0] & any_pend;

    // Read mux over the eight words; narrow words are zero-extended.
    always_comb begin
        case (sel)
            SEL_STATUS: bus_rdata = WORD_W'(status);
            SEL_PEND:   bus_rdata = WORD_W'(pend);
            SEL_ENABLE: bus_rdata = WORD_W'(enable);
            SEL_ACK:    bus_rdata = ack_rb;
            SEL_SETEN:  bus_rdata = set_rb;
            SEL_CLREN:  bus_rdata = clr_rb;
            SEL_VEC:    bus_rdata = vec;
            default:    bus_rdata = WORD_W'(master);
        endcase
    end

    // The encoder points at a pending bit and no lower bit is pending.
    assert_vec_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> (pend[vec[IDX_W-1:0]] &&
                     ((pend & ((N_SRC'(1) << vec[IDX_W-1:0]) - N_SRC'(1))) == '0)));

    // The encoder reads all ones with nothing pending.
    assert_vec_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend) |-> (&vec));

    // Dropping only the capture switch keeps a live interrupt up.
    assert_hie_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && sel == SEL_MASTER && master == 2'b11 &&
              bus_wdata[1:0] == 2'b01 && irq_out) |-> irq_out);

endmodule

// File: tb/test_irq_hub.sv
// Bench for irq_hub built with 8 lines: 0..3 level mode, 4..7 edge mode, command read-back on.
module test_irq_hub;

    localparam int         N     = 8;
    localparam logic [7:0] EMASK = 8'hF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_in = '0;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    // Arithmetic model state.
    logic [7:0]  m_sts, m_en, m_prev;
    logic [1:0]  m_me;
    logic [31:0] m_ack, m_set, m_clr;

    irq_hub #(.N_SRC(N), .EDGE_MASK(EMASK), .READBACK_CMD(1'b1)) i_irq_hub (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .irq_out   (irq_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] low_idx(input logic [7:0] p);
        for (int i = 0; i < 8; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    // One clock of stimulus; the model advances by the same rules.
    task automatic step(input bit wr, input logic [2:0] w, input logic [31:0] d,
                        input logic [7:0] inp, input logic [1:0] lo = 2'b00);
        logic [7:0] s, cap;
        bus_wr = wr; bus_addr = {w, lo}; bus_wdata = d; irq_in = inp;
        s = m_sts;
        if (wr && w == 3'd0 && !m_me[1]) s = d[7:0];
        if (wr && w == 3'd3) s = s & ~d[7:0];
        cap = m_me[1] ? ((inp & ~EMASK) | (inp & ~m_prev & EMASK)) : 8'h00;
        m_sts = s | cap;
        if (wr) begin
            case (w)
                3'd2: m_en = d[7:0];
                3'd3: m_ack = d;
                3'd4: begin m_en = m_en | d[7:0];  m_set = d; end
                3'd5: begin m_en = m_en & ~d[7:0]; m_clr = d; end
                3'd7: m_me = d[1:0];
                default: ;
            endcase
        end
        m_prev = inp;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Read every word plus the output and compare against the model.
    task automatic check_all(input string req);
        logic [31:0] exp [8];
        exp[0] = {24'h0, m_sts};
        exp[1] = {24'h0, m_sts & m_en};
        exp[2] = {24'h0, m_en};
        exp[3] = m_ack;
        exp[4] = m_set;
        exp[5] = m_clr;
        exp[6] = low_idx(m_sts & m_en);
        exp[7] = {30'h0, m_me};
        for (int w = 0; w < 8; w++) begin
            bus_addr = {w[2:0], 2'b00};
            #1;
            chk(req, $sformatf("word%0d", w), bus_rdata, exp[w]);
        end
        chk(req, "irq_out", {31'h0, irq_out}, {31'h0, m_me[0] && ((m_sts & m_en) != 0)});
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        m_sts = '0; m_en = '0; m_prev = '0; m_me = '0;
        m_ack = '0; m_set = '0; m_clr = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R2: low address bits do not change the selected word.
        step(1, 3'd2, 32'h0000_00A5, 8'h00, 2'b11);
        check_all("R2");
        step(1, 3'd2, 32'h0, 8'h00, 2'b01);
        check_all("R2");

        // R4 and R10: every status pattern stored with capture off, all enabled.
        step(1, 3'd2, 32'hFF, 8'h00);
        for (int p = 0; p < 256; p++) begin
            step(1, 3'd0, 32'(p), 8'h00);
            check_all(p == 0 ? "R10" : "R4");
        end
        // R3: every enable pattern against a full status word.
        step(1, 3'd0, 32'hFF, 8'h00);
        for (int e = 0; e < 256; e++) begin
            step(1, 3'd2, 32'(e), 8'h00);
            check_all("R3");
        end

        // R10: status write ignored while capture is on.
        step(1, 3'd0, 32'h0, 8'h00);
        step(1, 3'd7, 32'h2, 8'h00);
        step(1, 3'd0, 32'h0F, 8'h00);
        check_all("R10");

        // R6: plain write, atomic set and atomic clear.
        step(1, 3'd7, 32'h0, 8'h00);
        step(1, 3'd2, 32'h0F, 8'h00);
        step(1, 3'd4, 32'h30, 8'h00);
        check_all("R6");
        chk("R6", "enable after set", {24'h0, m_en}, 32'h3F);
        step(1, 3'd5, 32'h05, 8'h00);
        check_all("R6");
        chk("R6", "enable after clear", {24'h0, m_en}, 32'h3A);

        // R12: pending/vector writes ignored, master keeps two bits, read-back.
        step(1, 3'd0, 32'h12, 8'h00);
        step(1, 3'd1, 32'hFF, 8'h00);
        step(1, 3'd6, 32'h0, 8'h00);
        step(1, 3'd3, 32'hDEAD_BE00, 8'h00);
        step(1, 3'd7, 32'hFFFF_FFFC, 8'h00);
        check_all("R12");

        // Capture scenarios from a clean state.
        step(1, 3'd0, 32'h0, 8'h00);
        step(1, 3'd2, 32'hFF, 8'h00);
        step(1, 3'd7, 32'h3, 8'h00);
        check_all("R1");

        // R8: level lines re-capture through an acknowledge while high.
        step(0, 3'd0, 32'h0, 8'h03);
        check_all("R8");
        step(1, 3'd3, 32'h03, 8'h03);
        check_all("R8");
        step(0, 3'd0, 32'h0, 8'h00);
        step(1, 3'd3, 32'h03, 8'h00);
        check_all("R5");

        // R9: edge line sets once, stays clear after acknowledge while held high.
        step(0, 3'd0, 32'h0, 8'h10);
        check_all("R9");
        step(1, 3'd3, 32'h10, 8'h10);
        step(0, 3'd0, 32'h0, 8'h10);
        check_all("R9");
        step(0, 3'd0, 32'h0, 8'h00);
        step(0, 3'd0, 32'h0, 8'h10);
        check_all("R9");
        step(1, 3'd3, 32'hFF, 8'h00);

        // R7: no capture while switch is off; turning it on with lines held high.
        step(1, 3'd7, 32'h1, 8'h00);
        step(0, 3'd0, 32'h0, 8'h21);
        step(0, 3'd0, 32'h0, 8'h21);
        check_all("R7");
        step(1, 3'd7, 32'h3, 8'h21);
        step(0, 3'd0, 32'h0, 8'h21);
        check_all("R7");
        chk("R9", "held edge line not captured", {24'h0, m_sts}, 32'h01);

        // R11: dropping only the capture switch keeps the output high.
        step(1, 3'd7, 32'h1, 8'h00);
        check_all("R11");
        step(1, 3'd7, 32'h2, 8'h00);
        check_all("R11");
        step(1, 3'd7, 32'h0, 8'h00);
        step(1, 3'd3, 32'h01, 8'h00);
        check_all("R5");

        // Mixed pseudo-random run of writes and line changes.
        lcg = 32'h1234_5678;
        for (int k = 0; k < 1500; k++) begin
            logic [31:0] d;
            logic [7:0]  inp;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            d = {lcg[15:0], lcg[31:16]};
            inp = lcg[27:20];
            lcg = lcg * 32'd1103515245 + 32'd12345;
            step(lcg[20], lcg[18:16], d, inp, lcg[25:24]);
            check_all("R3");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule